// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes from a transmit buffer into asynchronous serial frames on a single output line. Bytes arrive over a valid/ready handshake. Each accepted byte leaves as one frame: a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop period that is one, one and a half or two bit times long. Bit timing comes from an external strobe that pulses once per oversample tick. Every bit lasts a fixed number of ticks, 16 by default.

Two flow-control gates decide whether a new frame may start. The hardware gate uses the active-low clear-to-send input. The software gate uses a pause flag that the receive side raises when it sees an XOFF. Neither gate cuts a frame short, because both act only between frames. A break request holds the line low for as long as it is asserted. When it is released, the line is held high for one full bit time before the next frame may begin. The frame format is sampled when a byte is accepted, so a format change made during a frame only affects later frames.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `txd` is high.
- R2: A frame begins on the clock edge that accepts a byte. `txd` goes low for a start bit, then the data bits follow, least significant bit first. Each bit lasts 16 ticks and changes on the edge that carries its 16th tick. `cfgDataLen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and byte bits above the selected length are never sent.
- R3: `cfgParity` selects the parity bit sent after the data bits. Code 0 sends no parity bit. Code 1 makes the count of ones, parity included, even. Code 2 makes that count odd. Code 3 always sends 1, and code 4 always sends 0. Codes 5 to 7 behave like code 0.
- R4: `cfgStop` code 0 gives a stop period of 16 ticks, and codes 2 and 3 give 32 ticks. `txd` is high for the whole stop period, and `busy` falls on the edge that carries the last stop tick.
- R5: `cfgStop` code 1 gives a 24-tick stop period with 5 data bits and a 32-tick stop period with any other data length.
- R6: When `cfgHwFlow` is 1 and `ctsN` is high, `inReady` is low and no frame starts. When `cfgHwFlow` is 0, `ctsN` is ignored. Raising `ctsN` during a frame does not change that frame.
- R7: When `cfgSwFlow` is 1 and `xoffPause` is high, `inReady` is low. A frame in progress when the pause rises still completes. Frames resume once the pause falls.
- R8: A `breakReq` seen while idle drives `txd` low from the next clock edge, and `txd` stays low while the request stays high. `inReady` is low while the request is high. A request raised during a frame takes effect only after that frame's stop period ends.
- R9: When a break is released, `txd` goes high on the next edge. `busy` then stays high for exactly 16 ticks, and only after that can a new byte be accepted.
- R10: The data length, parity mode and stop setting in force when a byte is accepted govern the whole frame of that byte. Changes made during the frame do not alter it.
- R11: A byte is taken on a clock edge where `inValid` and `inReady` are both high. `inReady` is low while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle oversample tick strobe, 16 per bit |
| inValid | input | 1 | Byte offered by the transmit buffer |
| inData | input | 8 | Offered byte |
| inReady | output | 1 | Block will take the offered byte on this edge |
| cfgDataLen | input | 2 | Data length code (0..3 → 5..8 bits) |
| cfgStop | input | 2 | Stop length code (0: 1, 1: 1.5, 2/3: 2 bit times) |
| cfgParity | input | 3 | Parity code (0 none, 1 even, 2 odd, 3 mark, 4 space) |
| cfgHwFlow | input | 1 | Enable clear-to-send gating |
| cfgSwFlow | input | 1 | Enable software pause gating |
| ctsN | input | 1 | Active-low clear-to-send |
| xoffPause | input | 1 | Pause flag from the receive side |
| breakReq | input | 1 | Hold the line low while high |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame, break or post-break guard in progress |

## Verification
The start bit shows on `txd` one clock after the accepting edge. After that, each bit boundary falls on the edge that carries the 16th tick of that bit, so the bench counts ticks from the handshake and samples every bit eight ticks into it, well clear of both edges. Each tick pulse is followed by a quiet cycle before sampling, which gives the registered output time to settle. The stop period is probed one tick before its expected end, where `busy` must still be high, and again at the end, where `busy` must be low; a stop length that is wrong by a single tick therefore shows up. For break release, the line is checked on the first edge after release, then one tick before the guard ends and at the tick where it ends.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } parMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_BREAK,
    ST_GUARD
  } txState_e;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
    logic emitParity;
    logic driveMark;
    logic driveSpace;
  } txStrobe_t;

  function automatic logic parityUsed(logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd4);
  endfunction

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       inValid,
  input  logic       breakReq,
  input  logic       ctsN,
  input  logic       xoffPause,
  input  logic       cfgHwFlow,
  input  logic       cfgSwFlow,
  input  logic [1:0] cfgDataLen,
  input  logic [1:0] cfgStop,
  input  logic [2:0] cfgParity,
  output logic       inReady,
  output logic       busy,
  output txStrobe_t  strb
);

  localparam int unsigned HALF_BIT = TICKS_PER_BIT / 2;
  localparam int unsigned CNT_W    = $clog2(2 * TICKS_PER_BIT + 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(TICKS_PER_BIT + HALF_BIT - 1);
  localparam logic [CNT_W-1:0] TWO_LAST  = CNT_W'(2 * TICKS_PER_BIT - 1);

  txState_e         state, nextState;
  logic [CNT_W-1:0] tickCnt;
  logic [2:0]       bitIdx;
  logic [2:0]       lastIdx;
  logic             parEnR;
  logic [CNT_W-1:0] stopLastR;
  logic [CNT_W-1:0] stopLastNew;

  logic accept, bitEnd, cntClr, cntInc, bitClr, bitInc;

  assign inReady = (state == ST_IDLE) && !breakReq
                   && (!cfgHwFlow || !ctsN)
                   && (!cfgSwFlow || !xoffPause);
  assign accept  = inValid && inReady;
  assign busy    = (state != ST_IDLE);
  assign bitEnd  = tick16 && (tickCnt == BIT_LAST);

  always_comb begin
    case (cfgStop)
      2'd0:    stopLastNew = BIT_LAST;
      2'd1:    stopLastNew = (cfgDataLen == 2'd0) ? HALF_LAST : TWO_LAST;
      default: stopLastNew = TWO_LAST;
    endcase
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    cntClr    = 1'b0;
    cntInc    = 1'b0;
    bitClr    = 1'b0;
    bitInc    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (breakReq) begin
          nextState       = ST_BREAK;
          strb.driveSpace = 1'b1;
        end else if (accept) begin
          nextState      = ST_START;
          strb.loadFrame = 1'b1;
          cntClr         = 1'b1;
        end
      end
      ST_START: begin
        if (bitEnd) begin
          nextState     = ST_DATA;
          strb.shiftBit = 1'b1;
          cntClr        = 1'b1;
          bitClr        = 1'b1;
        end else if (tick16) begin
          cntInc = 1'b1;
        end
      end
      ST_DATA: begin
        if (bitEnd) begin
          cntClr = 1'b1;
          if (bitIdx == lastIdx) begin
            if (parEnR) begin
              nextState       = ST_PARITY;
              strb.emitParity = 1'b1;
            end else begin
              nextState      = ST_STOP;
              strb.driveMark = 1'b1;
            end
          end else begin
            bitInc        = 1'b1;
            strb.shiftBit = 1'b1;
          end
        end else if (tick16) begin
          cntInc = 1'b1;
        end
      end
      ST_PARITY: begin
        if (bitEnd) begin
          nextState      = ST_STOP;
          strb.driveMark = 1'b1;
          cntClr         = 1'b1;
        end else if (tick16) begin
          cntInc = 1'b1;
        end
      end
      ST_STOP: begin
        if (tick16) begin
          if (tickCnt == stopLastR) begin
            nextState = ST_IDLE;
            cntClr    = 1'b1;
          end else begin
            cntInc = 1'b1;
          end
        end
      end
      ST_BREAK: begin
        if (!breakReq) begin
          nextState      = ST_GUARD;
          strb.driveMark = 1'b1;
          cntClr         = 1'b1;
        end
      end
      ST_GUARD: begin
        if (bitEnd) begin
          nextState = ST_IDLE;
          cntClr    = 1'b1;
        end else if (tick16) begin
          cntInc = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      lastIdx   <= 3'd7;
      parEnR    <= 1'b0;
      stopLastR <= BIT_LAST;
    end else begin
      state <= nextState;
      if (cntClr)      tickCnt <= '0;
      else if (cntInc) tickCnt <= tickCnt + 1'b1;
      if (bitClr)      bitIdx <= '0;
      else if (bitInc) bitIdx <= bitIdx + 1'b1;
      if (strb.loadFrame) begin
        lastIdx   <= 3'(cfgDataLen) + 3'd4;
        parEnR    <= parityUsed(cfgParity);
        stopLastR <= stopLastNew;
      end
    end
  end

  // stop counter never runs past the latched stop length
  p_stop_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP) |-> (tickCnt <= stopLastR));

  // frame format registers hold for the whole frame
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((state != ST_IDLE) && $past(state != ST_IDLE))
      |-> ($stable(stopLastR) && $stable(lastIdx) && $stable(parEnR)));

  // leaving a break always passes through the guard bit
  p_guard_after_break_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state == ST_BREAK) && (state != ST_BREAK)) |-> (state == ST_GUARD));

endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [BYTE_W-1:0] inData,
  input  logic [1:0]        cfgDataLen,
  input  logic [2:0]        cfgParity,
  output logic              txd
);

  logic [BYTE_W-1:0] lenMask;
  logic [BYTE_W-1:0] maskedData;
  logic [BYTE_W-1:0] shiftReg;
  logic              parBitNew;
  logic              parBitR;
  logic              txdR;

  assign lenMask    = {BYTE_W{1'b1}} >> (2'd3 - cfgDataLen);
  assign maskedData = inData & lenMask;

  always_comb begin
    case (cfgParity)
      PAR_EVEN:  parBitNew = ^maskedData;
      PAR_ODD:   parBitNew = ~^maskedData;
      PAR_MARK:  parBitNew = 1'b1;
      default:   parBitNew = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBitR  <= 1'b0;
      txdR     <= 1'b1;
    end else if (strb.loadFrame) begin
      shiftReg <= maskedData;
      parBitR  <= parBitNew;
      txdR     <= 1'b0;
    end else if (strb.shiftBit) begin
      txdR     <= shiftReg[0];
      shiftReg <= shiftReg >> 1;
    end else if (strb.emitParity) begin
      txdR <= parBitR;
    end else if (strb.driveMark) begin
      txdR <= 1'b1;
    end else if (strb.driveSpace) begin
      txdR <= 1'b0;
    end
  end

  assign txd = txdR;

  // control never issues two line actions in one cycle
  p_one_action_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       inValid,
  input  logic [7:0] inData,
  output logic       inReady,
  input  logic [1:0] cfgDataLen,
  input  logic [1:0] cfgStop,
  input  logic [2:0] cfgParity,
  input  logic       cfgHwFlow,
  input  logic       cfgSwFlow,
  input  logic       ctsN,
  input  logic       xoffPause,
  input  logic       breakReq,
  output logic       txd,
  output logic       busy
);

  txStrobe_t strb;

  uart_tx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tick16     (tick16),
    .inValid    (inValid),
    .breakReq   (breakReq),
    .ctsN       (ctsN),
    .xoffPause  (xoffPause),
    .cfgHwFlow  (cfgHwFlow),
    .cfgSwFlow  (cfgSwFlow),
    .cfgDataLen (cfgDataLen),
    .cfgStop    (cfgStop),
    .cfgParity  (cfgParity),
    .inReady    (inReady),
    .busy       (busy),
    .strb       (strb)
  );

  uart_tx_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .inData     (inData),
    .cfgDataLen (cfgDataLen),
    .cfgParity  (cfgParity),
    .txd        (txd)
  );

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txd);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (!txd && busy));

  p_cts_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgHwFlow && ctsN) |-> !inReady);

  p_xoff_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSwFlow && xoffPause) |-> !inReady);

  p_break_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> !inReady);

  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !inReady);

endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inReady;
  logic [1:0] cfgDataLen = 2'd3;
  logic [1:0] cfgStop = 2'd0;
  logic [2:0] cfgParity = 3'd0;
  logic       cfgHwFlow = 1'b0;
  logic       cfgSwFlow = 1'b0;
  logic       ctsN = 1'b0;
  logic       xoffPause = 1'b0;
  logic       breakReq = 1'b0;
  logic       txd;
  logic       busy;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  uart_frame_tx dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .inValid(inValid),
    .inData(inData), .inReady(inReady), .cfgDataLen(cfgDataLen),
    .cfgStop(cfgStop), .cfgParity(cfgParity), .cfgHwFlow(cfgHwFlow),
    .cfgSwFlow(cfgSwFlow), .ctsN(ctsN), .xoffPause(xoffPause),
    .breakReq(breakReq), .txd(txd), .busy(busy)
  );

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tickN(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick16 = 1'b1;
      @(negedge clk) tick16 = 1'b0;
      @(negedge clk);
    end
  endtask

  function automatic logic expBit(int b, logic [7:0] d, int len, int par);
    logic [7:0] m;
    m = d & 8'((1 << len) - 1);
    if (b == 0) return 1'b0;
    if (b <= len) return d[b-1];
    case (par)
      1: return ^m;
      2: return ~^m;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // mid: 0 none, 1 raise xoff, 2 raise break, 3 scramble format, 4 raise ctsN
  task automatic sendCheck(string tag, logic [7:0] d, int lenCode, int par,
                           int stopCode, int mid);
    int len = lenCode + 5;
    int nb  = 1 + len + ((par >= 1 && par <= 4) ? 1 : 0);
    int ts  = (stopCode == 0) ? 16 : ((stopCode == 1 && len == 5) ? 24 : 32);
    @(negedge clk);
    cfgDataLen = 2'(lenCode);
    cfgParity  = 3'(par);
    cfgStop    = 2'(stopCode);
    inValid    = 1'b1;
    inData     = d;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    inData  = 8'h00;
    chk({tag, " R2 start bit low"}, txd, 1'b0);
    chk({tag, " R11 busy after accept"}, busy, 1'b1);
    case (mid)
      1: xoffPause = 1'b1;
      2: breakReq = 1'b1;
      3: begin
        cfgDataLen = ~cfgDataLen;
        cfgParity  = (par == 0) ? 3'd1 : 3'd0;
        cfgStop    = (stopCode == 0) ? 2'd2 : 2'd0;
      end
      4: ctsN = 1'b1;
      default: ;
    endcase
    for (int b = 0; b < nb; b++) begin
      tickN(8);
      chk($sformatf("%s R2 R3 bit %0d", tag, b), txd, expBit(b, d, len, par));
      if (b == 1) chk({tag, " R11 ready low in frame"}, inReady, 1'b0);
      tickN(8);
    end
    tickN(8);
    chk({tag, " R4 stop high"}, txd, 1'b1);
    tickN(ts - 9);
    chk({tag, " R4 R5 busy before stop end"}, busy, 1'b1);
    tickN(1);
    if (mid == 2) chk({tag, " R8 break after frame"}, txd, 1'b0);
    else          chk({tag, " R4 R5 idle at stop end"}, busy, 1'b0);
  endtask

  task automatic releaseBreak(string tag);
    @(negedge clk) breakReq = 1'b0;
    @(negedge clk);
    chk({tag, " R9 line high after release"}, txd, 1'b1);
    chk({tag, " R9 busy in guard"}, busy, 1'b1);
    chk({tag, " R9 ready low in guard"}, inReady, 1'b0);
    tickN(15);
    chk({tag, " R9 guard not over early"}, busy, 1'b0 + 1'b1);
    tickN(1);
    chk({tag, " R9 idle after guard"}, busy, 1'b0);
    chk({tag, " R9 ready after guard"}, inReady, 1'b1);
    chk({tag, " R1 idle high"}, txd, 1'b1);
  endtask

  task automatic testReset();
    chk("R1 reset txd", txd, 1'b1);
    chk("R1 reset busy", busy, 1'b0);
    chk("R11 reset ready", inReady, 1'b1);
  endtask

  task automatic testFormats();
    sendCheck("8N1", 8'hA5, 3, 0, 0, 0);
    sendCheck("5E1.5 upper bits dropped", 8'hF3, 0, 1, 1, 0);
    sendCheck("7O2", 8'h5C, 2, 2, 2, 0);
    sendCheck("6 mark half-stop as two", 8'h2A, 1, 3, 1, 0);
    sendCheck("8 space stop3", 8'h81, 3, 4, 3, 0);
    sendCheck("8E1", 8'h7E, 3, 1, 0, 0);
    sendCheck("6 odd zero", 8'h00, 1, 2, 0, 0);
    sendCheck("5 code7 no parity", 8'h15, 0, 7, 0, 0);
  endtask

  task automatic testCfgHold();
    sendCheck("R10 format latched", 8'h96, 3, 1, 0, 3);
    sendCheck("R10 half stop latched", 8'h0B, 0, 2, 1, 3);
  endtask

  task automatic testHwFlow();
    cfgHwFlow = 1'b1;
    ctsN = 1'b1;
    @(negedge clk) begin inValid = 1'b1; inData = 8'h3C; end
    tickN(20);
    chk("R6 ready low on cts high", inReady, 1'b0);
    chk("R6 no frame on cts high", txd, 1'b1);
    chk("R6 not busy on cts high", busy, 1'b0);
    inValid = 1'b0;
    ctsN = 1'b0;
    sendCheck("R6 cts drop mid frame", 8'h3C, 3, 0, 0, 4);
    chk("R6 held after frame", inReady, 1'b0);
    cfgHwFlow = 1'b0;
    sendCheck("R6 cts ignored when off", 8'h11, 3, 0, 0, 0);
    ctsN = 1'b0;
  endtask

  task automatic testSwFlow();
    cfgSwFlow = 1'b1;
    sendCheck("R7 xoff mid frame", 8'hC3, 3, 0, 0, 1);
    chk("R7 paused after frame", inReady, 1'b0);
    tickN(20);
    chk("R7 line idle while paused", txd, 1'b1);
    chk("R7 not busy while paused", busy, 1'b0);
    xoffPause = 1'b0;
    @(negedge clk);
    chk("R7 resume on xon", inReady, 1'b1);
    cfgSwFlow = 1'b0;
    xoffPause = 1'b1;
    @(negedge clk);
    chk("R7 pause ignored when off", inReady, 1'b1);
    xoffPause = 1'b0;
  endtask

  task automatic testBreak();
    @(negedge clk) breakReq = 1'b1;
    @(negedge clk);
    chk("R8 low next cycle", txd, 1'b0);
    chk("R8 busy in break", busy, 1'b1);
    inValid = 1'b1;
    inData  = 8'hFF;
    tickN(40);
    chk("R8 held low", txd, 1'b0);
    chk("R8 ready low in break", inReady, 1'b0);
    inValid = 1'b0;
    releaseBreak("idle break");
  endtask

  task automatic testBreakMid();
    sendCheck("R8 break waits for frame", 8'h55, 3, 0, 0, 2);
    tickN(5);
    chk("R8 still low", txd, 1'b0);
    releaseBreak("mid break");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFormats();
    testCfgHold();
    testHwFlow();
    testSwFlow();
    testBreak();
    testBreakMid();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule